// File: doc/BRIEF.md
# Line-Merging Read Request Coalescer

This block takes one read request per lane from a group of sixteen SIMD lanes and turns the group into as few memory bus requests as possible. Every lane gives a byte address and a flag saying whether it wants data. The bus moves whole aligned 32-byte lines. For that reason each lane address is rounded down to its line, and all lanes that land on the same line share one request.

The distinct lines leave the block one per cycle on a valid/ready output. Each line comes with a mask of the lanes it serves, so that a later stage can send the returned data to the right lanes. A group is taken on a valid/ready input and held until its last line has been accepted downstream. When the group is finished, the block raises a one-cycle done pulse and reports how many lines the group used. This count is a direct measure of bus utilisation.

Top module: `coal_unit`

## Requirements
- R1: Each issued line address equals a lane's byte address with its low 5 bits forced to zero. For example, lane addresses 0x00001220 through 0x0000123F all give line 0x00001220.
- R2: Within one group, every distinct line among the valid lanes is issued exactly once. Sixteen consecutive 4-byte words from 0x00001232 use 3 lines, from 0x00001220 they use 2, and sixteen lanes on one address use 1.
- R3: Lines leave in ascending order of the lowest-numbered lane that needs each of them.
- R4: Bit i of `out_lane_mask` (bit 0 = lane 0) is 1 exactly when lane i is valid and its address lies in the issued line.
- R5: A lane whose valid bit is 0 has no effect on any issued line or mask, whatever its address.
- R6: A group with no valid lanes issues no line. `grp_done` rises in the cycle after that group is accepted, with `grp_line_count` equal to 0.
- R7: `in_ready` is 0 while any line of the current group is not yet accepted. A new group is taken only when `in_valid` and `in_ready` are both 1 at a clock edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_line_addr` and `out_lane_mask` hold their values into the next cycle.
- R9: `grp_done` is a one-cycle pulse in the cycle after the last line of a group is accepted. In that cycle `grp_line_count` equals the number of lines the group issued.
- R10: After reset, `out_valid` and `grp_done` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A lane group is offered |
| in_ready | output | 1 | The block can take a group |
| in_lane_valid | input | 16 | Per-lane request flags, bit i = lane i |
| in_addr | input | 512 | Lane byte addresses, lane i at bits [32*i+31:32*i] |
| out_valid | output | 1 | A line request is offered |
| out_ready | input | 1 | Downstream accepts the line |
| out_line_addr | output | 32 | Aligned line address |
| out_lane_mask | output | 16 | Lanes served by this line |
| grp_done | output | 1 | One-cycle pulse when a group has finished |
| grp_line_count | output | 5 | Lines issued by the finished group |

## Verification
Two events can happen in the same clock: the done pulse of one group and the acceptance of the next group. They coincide because `in_ready` rises in the same cycle that `grp_done` is reported. The bench makes this happen by offering each new group as soon as `in_ready` is seen, so back-to-back groups, including empty ones, meet the finishing group's pulse. A behavioural model runs in step with the design and compares every cycle. It checks that the finished group's count is correct and that the new group's first line appears one cycle after acceptance, with no lane carried over from the old group.

// File: rtl/coal_pkg.sv
package coal_pkg;
   localparam int unsigned DEF_LANES      = 16;
   localparam int unsigned DEF_ADDR_W     = 32;
   localparam int unsigned DEF_LINE_BYTES = 32;

   function automatic logic [DEF_ADDR_W-1:0] line_of(input logic [DEF_ADDR_W-1:0] a,
                                                     input int unsigned off_w);
      logic [DEF_ADDR_W-1:0] m;
      m = '1;
      m = m << off_w;
      return a & m;
   endfunction
endpackage

// File: rtl/coal_first_lane.sv
module coal_first_lane #(
   parameter int unsigned LANES = 16,
   localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0] pend,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
   end
   assign any = |pend;
endmodule

// File: rtl/coal_match.sv
module coal_match #(
   parameter int unsigned LANES  = 16,
   parameter int unsigned ADDR_W = 32
) (
   input  logic [LANES-1:0]  pend,
   input  logic [ADDR_W-1:0] lines [LANES],
   input  logic [ADDR_W-1:0] head,
   output logic [LANES-1:0]  hit
);
   for (genvar g = 0; g < LANES; g++) begin : g_cmp
      assign hit[g] = pend[g] && (lines[g] == head);
   end
endmodule

// File: rtl/coal_unit.sv
module coal_unit
   import coal_pkg::*;
#(
   parameter int unsigned LANES      = DEF_LANES,
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
   localparam int unsigned OFF_W = $clog2(LINE_BYTES),
   localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANES-1:0]        in_lane_valid,
   input  logic [LANES*ADDR_W-1:0] in_addr,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [ADDR_W-1:0]       out_line_addr,
   output logic [LANES-1:0]        out_lane_mask,
   output logic                    grp_done,
   output logic [CNT_W-1:0]        grp_line_count
);
   if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("coal_unit: LINE_BYTES must be a power of two, at least 4");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("coal_unit: LANES must be at least 2");
   end
   if (ADDR_W != DEF_ADDR_W) begin : g_bad_addr
      $error("coal_unit: ADDR_W must match the package address width");
   end

   logic [LANES-1:0]  pend_q;
   logic [ADDR_W-1:0] line_q [LANES];
   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;

   logic [IDX_W-1:0]  head_idx;
   logic              busy;
   logic [ADDR_W-1:0] head_line;
   logic [LANES-1:0]  hit;
   logic              in_fire, out_fire;

   coal_first_lane #(.LANES(LANES)) u_first (
      .pend (pend_q),
      .idx  (head_idx),
      .any  (busy)
   );

   assign head_line = line_q[head_idx];

   coal_match #(.LANES(LANES), .ADDR_W(ADDR_W)) u_match (
      .pend  (pend_q),
      .lines (line_q),
      .head  (head_line),
      .hit   (hit)
   );

   assign in_ready       = !busy;
   assign in_fire        = in_valid && in_ready;
   assign out_valid      = busy;
   assign out_fire       = busy && out_ready;
   assign out_line_addr  = head_line;
   assign out_lane_mask  = hit;
   assign grp_done       = done_q;
   assign grp_line_count = cnt_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_q[g] <= '0;
         end else if (in_fire) begin
            line_q[g] <= line_of(in_addr[g*ADDR_W +: ADDR_W], OFF_W);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (in_fire) begin
            pend_q <= in_lane_valid;
            cnt_q  <= '0;
            if (in_lane_valid == '0) done_q <= 1'b1;
         end else if (out_fire) begin
            pend_q <= pend_q & ~hit;
            cnt_q  <= cnt_q + 1'b1;
            if ((pend_q & ~hit) == '0) done_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/coal_unit_chk.sv
module coal_unit_chk #(
   parameter int unsigned LANES      = 16,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 32,
   localparam int unsigned OFF_W = $clog2(LINE_BYTES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_line_addr,
   input logic [LANES-1:0]  out_lane_mask,
   input logic              grp_done
);
   assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_line_addr[OFF_W-1:0] == '0);

   assert_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (!out_valid || ((out_lane_mask & $past(out_lane_mask)) == '0)));

   assert_mask_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_lane_mask != '0);

   assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_line_addr) && $stable(out_lane_mask)));

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      grp_done |-> (in_ready && !out_valid));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_done && $past(grp_done)) |-> $past(in_ready));
endmodule

bind coal_unit coal_unit_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_ready      (in_ready),
   .out_valid     (out_valid),
   .out_ready     (out_ready),
   .out_line_addr (out_line_addr),
   .out_lane_mask (out_lane_mask),
   .grp_done      (grp_done)
);

// File: tb/test_coal_unit.sv
module test_coal_unit;
   localparam int LANES = 16;
   localparam int AW    = 32;
   localparam int CLK_PERIOD = 10;

   logic             clk = 0;
   logic             rst_n = 0;
   logic             in_valid = 0;
   logic             in_ready;
   logic [LANES-1:0] in_lane_valid = '0;
   logic [LANES*AW-1:0] in_addr = '0;
   logic             out_valid;
   logic             out_ready = 1;
   logic [AW-1:0]    out_line_addr;
   logic [LANES-1:0] out_lane_mask;
   logic             grp_done;
   logic [4:0]       grp_line_count;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit ready_rand = 0;
   bit model_on = 0;

   logic [AW-1:0]    ql [$];
   logic [LANES-1:0] qm [$];
   bit               e_done = 0;
   int               e_cnt = 0;
   int               acc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   coal_unit i_coal_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_lane_valid(in_lane_valid), .in_addr(in_addr), .out_valid(out_valid),
      .out_ready(out_ready), .out_line_addr(out_line_addr), .out_lane_mask(out_lane_mask),
      .grp_done(grp_done), .grp_line_count(grp_line_count)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // Reference model: advanced at every falling edge, after comparing outputs.
   always @(negedge clk) begin
      bit nd;
      if (model_on) begin
         cycles++;
         chk(out_valid == (ql.size() > 0), "R7 out_valid", out_valid, ql.size() > 0);
         chk(in_ready == (ql.size() == 0), "R7 in_ready", in_ready, ql.size() == 0);
         if (ql.size() > 0 && out_valid) begin
            chk(out_line_addr == ql[0], "R1/R3 line address", out_line_addr, ql[0]);
            chk(out_lane_mask == qm[0], "R4/R5 lane mask", out_lane_mask, qm[0]);
         end
         chk(grp_done == e_done, "R6/R9 done pulse", grp_done, e_done);
         if (e_done) chk(grp_line_count == e_cnt, "R9 line count", grp_line_count, e_cnt);
         nd = 0;
         if (ql.size() > 0 && out_ready) begin
            void'(ql.pop_front()); void'(qm.pop_front());
            acc++;
            if (ql.size() == 0) begin nd = 1; e_cnt = acc; end
         end else if (ql.size() == 0 && in_valid) begin
            bit used [LANES];
            acc = 0;
            for (int i = 0; i < LANES; i++) used[i] = 0;
            for (int i = 0; i < LANES; i++) begin
               if (in_lane_valid[i] && !used[i]) begin
                  logic [AW-1:0] ln;
                  logic [LANES-1:0] m;
                  ln = in_addr[i*AW +: AW] & 32'hFFFF_FFE0;
                  m = '0;
                  for (int j = 0; j < LANES; j++)
                     if (in_lane_valid[j] && ((in_addr[j*AW +: AW] & 32'hFFFF_FFE0) == ln)) begin
                        m[j] = 1; used[j] = 1;
                     end
                  ql.push_back(ln); qm.push_back(m);
               end
            end
            if (ql.size() == 0) begin nd = 1; e_cnt = 0; end
         end
         e_done = nd;
      end
   end

   always @(posedge clk) begin
      #1;
      if (ready_rand) out_ready = ($urandom % 4) != 0;
   end

   logic [AW-1:0] av [LANES];

   task automatic send(input logic [LANES-1:0] v, input int exp_lines, input string req);
      int guard;
      while (!in_ready) begin @(posedge clk); #1; end
      in_valid = 1;
      in_lane_valid = v;
      for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = av[i];
      @(posedge clk); #1;
      in_valid = 0;
      in_addr = {LANES*AW{1'b1}};
      guard = 0;
      while (!grp_done && guard < 500) begin @(posedge clk); #1; guard++; end
      chk(grp_done == 1, {req, " group finished"}, grp_done, 1);
      chk(grp_line_count == exp_lines, {req, " lines per group"}, grp_line_count, exp_lines);
   endtask

   initial begin
      #(CLK_PERIOD*1000*50);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD*3 + 2);
      chk(out_valid == 0, "R10 out_valid in reset", out_valid, 0);
      chk(in_ready == 1, "R10 in_ready in reset", in_ready, 1);
      chk(grp_done == 0, "R10 done in reset", grp_done, 0);
      rst_n = 1;
      @(posedge clk); #1;
      model_on = 1;

      // R2: unaligned consecutive words -> 3 lines
      for (int i = 0; i < LANES; i++) av[i] = 32'h1232 + 4*i;
      send('1, 3, "R2 unaligned run");
      // R2: aligned -> 2 lines
      for (int i = 0; i < LANES; i++) av[i] = 32'h1220 + 4*i;
      send('1, 2, "R2 aligned run");
      // R2: broadcast one address -> 1 line
      for (int i = 0; i < LANES; i++) av[i] = 32'h0000_5A5C;
      send('1, 1, "R2 same address");
      // R1: range 0x1220..0x123F collapse to one line
      for (int i = 0; i < LANES; i++) av[i] = 32'h1220 + 2*i + (i == 15 ? 1 : 0);
      send('1, 1, "R1 line range");
      // R6: empty group, back to back
      send('0, 0, "R6 empty group");
      send('0, 0, "R6 empty group again");
      // R5: invalid lanes with distinct addresses ignored
      for (int i = 0; i < LANES; i++) av[i] = (i % 2 == 0) ? 32'h8000 : 32'h100 * i;
      send(16'h5555, 1, "R5 odd lanes off");
      // R3: reverse order, stride 32 -> 16 lines, issue follows lane order
      for (int i = 0; i < LANES; i++) av[i] = 32'hF000 - 32*i;
      send('1, 16, "R3 descending lines");
      // R8/R7: random backpressure with random groups
      ready_rand = 1;
      for (int i = 0; i < LANES; i++) av[i] = 32'h4000 + 4*i;
      send('1, 2, "R8 backpressure run");
      for (int k = 0; k < 60; k++) begin
         logic [LANES-1:0] v;
         v = LANES'($urandom);
         for (int i = 0; i < LANES; i++) av[i] = 32'h2000 + ($urandom % 8) * 32 + ($urandom % 32);
         begin
            int n;
            bit seen [8];
            n = 0;
            for (int s = 0; s < 8; s++) seen[s] = 0;
            for (int i = 0; i < LANES; i++)
               if (v[i] && !seen[(av[i] - 32'h2000) / 32]) begin
                  seen[(av[i] - 32'h2000) / 32] = 1; n++;
               end
            send(v, n, "R2/R7 random group");
         end
      end
      ready_rand = 0; out_ready = 1;
      repeat (4) @(posedge clk);
      #1;
      chk(in_ready == 1 && out_valid == 0, "R7 idle at end", {in_ready, out_valid}, 2'b10);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule